// File: doc/BRIEF.md
# Seven-Level Rectifier PWM Modulator

This block turns a normalized control word into gate commands for a step-down rectifier whose switching node can take seven levels. A triangle carrier from an up/down counter runs with a period of `2*TOP` clocks. The control word splits into three equal thirds. Each third selects one switching region, and each region modulates a different switch set. In the lowest region the rectifier leg of the present input polarity is modulated. In the middle region the group that adds the first flying capacitor is modulated. In the top region the group that adds the second flying capacitor is modulated. Every modulated command has a complementary command, and the block inserts a programmable dead gap between the two.

The control word, the polarity bit and the balancing request are captured only at the carrier valley, so a whole period runs on one set of values. The balancing mode flips an arrangement-select command at every period start, so the two capacitor arrangements that both produce the doubled level take turns. On the flipped periods the middle and top regions compare against a mirrored carrier, which shifts the pulse by half a period. When the enable is low, every output goes low at the next clock.

Top module: `sevlvl_mod`

## Requirements
- R1: Under reset, and from the first clock edge at which `mod_en` is sampled low, all nine gate outputs are 0.
- R2: With `TOP` = carrier peak, a captured word `k < TOP` selects the low region, `TOP <= k < 2*TOP` selects the mid region, and `k >= 2*TOP` selects the top region. Words above `3*TOP` act as `3*TOP`.
- R3: The local duty is `d = k - r*TOP` (r = 0, 1, 2 for low, mid, top). The modulated raw command is high for `2*d-1` clocks of each `2*TOP`-clock period, or for 0 clocks when d = 0.
- R4: In the low region, `g_rp` is modulated when `pol_pos`=1 and `g_rn` is modulated when `pol_pos`=0. The other rectifier main, `g_mid` and `g_top` are off, and `g_rp` and `g_rn` are never on together.
- R5: In the mid region, the rectifier main of the captured polarity is held on, `g_mid` is modulated and `g_top` is off.
- R6: In the top region, the rectifier main of the captured polarity and `g_mid` are held on, and `g_top` is modulated.
- R7: Each `_n` output is the complement of its main output. After every change of the raw command, both outputs of the pair are off for `dead_clks` clocks, and a pair is never on at both outputs.
- R8: `g_top` is on only while `g_mid` is on.
- R9: `ctrl_word`, `pol_pos` and `bal_en` take effect only at the next period start. A change in mid-period leaves the on-count of the current period unchanged.
- R10: While `bal_en`=1, `g_arr` toggles at every period start (high for half of all periods). While `bal_en`=0 it stays 0. Mirroring the carrier on `g_arr` periods leaves the per-period on-count of R3 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mod_en | input | 1 | Modulator run enable; low forces all gates off and restarts the carrier |
| ctrl_word | input | CTRL_W | Control word, full scale 3*TOP |
| pol_pos | input | 1 | Input polarity, 1 = positive |
| bal_en | input | 1 | Request alternation of the two doubled-level capacitor arrangements |
| dead_clks | input | DT_W | Dead gap in clocks between a command and its complement |
| g_rp | output | 1 | Positive-leg rectifier main switch |
| g_rp_n | output | 1 | Positive-leg diode-position complement |
| g_rn | output | 1 | Negative-leg rectifier main switch |
| g_rn_n | output | 1 | Negative-leg diode-position complement |
| g_mid | output | 1 | First flying-capacitor group (middle region) |
| g_mid_n | output | 1 | Complement of the first group |
| g_top | output | 1 | Second flying-capacitor group (top region) |
| g_top_n | output | 1 | Complement of the second group |
| g_arr | output | 1 | Doubled-level arrangement select, toggles under balancing |

## Verification
A wrong captured region or duty appears within one carrier period. It shows as an on-count per period that differs from `2*d-1`, or as a held-on or held-off group that should be modulating. A stray carrier direction or a missed valley shifts the period length, so the counts over a window of four periods drift at once. A dead-gap counter that is stuck or loaded wrongly shows at the next edge of the raw command: both outputs of a pair are on together, or the complement count is off by the gap. A balancing toggle that is lost shows as `g_arr` staying constant for two periods.

// File: rtl/sevlvl_pkg.sv
package sevlvl_pkg;
   typedef enum logic [1:0] {
      RG_LOW  = 2'd0,
      RG_MID  = 2'd1,
      RG_HIGH = 2'd2
   } region_e;

   // raw command slots, one per switch pair
   localparam int NPAIR   = 4;
   localparam int IDX_RP  = 0;
   localparam int IDX_RN  = 1;
   localparam int IDX_MID = 2;
   localparam int IDX_TOP = 3;
endpackage

// File: rtl/sevlvl_carrier.sv
module sevlvl_carrier #(
   parameter int CNT_W = 10,
   parameter int TOP   = 42
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   output logic [CNT_W-1:0] cnt,
   output logic             start_nxt
);
   localparam logic [CNT_W-1:0] TOPV = CNT_W'(TOP);
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

   logic down;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         down <= 1'b0;
      end else if (!run) begin
         cnt  <= '0;
         down <= 1'b0;
      end else if (!down) begin
         cnt <= cnt + ONE;
         if (cnt + ONE == TOPV) down <= 1'b1;
      end else begin
         cnt <= cnt - ONE;
         if (cnt == ONE) down <= 1'b0;
      end
   end

   // next count is the valley: a new period starts
   assign start_nxt = run && down && (cnt == ONE);
endmodule

// File: rtl/sevlvl_sample.sv
module sevlvl_sample
   import sevlvl_pkg::*;
#(
   parameter int CNT_W  = 10,
   parameter int CTRL_W = 10,
   parameter int TOP    = 42
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              start_nxt,
   input  logic [CTRL_W-1:0] ctrl,
   input  logic              pol_in,
   input  logic              bal_in,
   output region_e           rg,
   output logic [CNT_W-1:0]  duty,
   output logic              pol,
   output logic              arr
);
   localparam logic [CTRL_W-1:0] T1 = CTRL_W'(TOP);
   localparam logic [CTRL_W-1:0] T2 = CTRL_W'(2 * TOP);
   localparam logic [CTRL_W-1:0] T3 = CTRL_W'(3 * TOP);

   region_e          rg_n;
   logic [CNT_W-1:0] duty_n;

   always_comb begin
      if (ctrl < T1) begin
         rg_n   = RG_LOW;
         duty_n = CNT_W'(ctrl);
      end else if (ctrl < T2) begin
         rg_n   = RG_MID;
         duty_n = CNT_W'(ctrl - T1);
      end else if (ctrl < T3) begin
         rg_n   = RG_HIGH;
         duty_n = CNT_W'(ctrl - T2);
      end else begin
         rg_n   = RG_HIGH;
         duty_n = CNT_W'(TOP);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rg   <= RG_LOW;
         duty <= '0;
         pol  <= 1'b0;
         arr  <= 1'b0;
      end else if (!run) begin
         rg   <= rg_n;
         duty <= duty_n;
         pol  <= pol_in;
         arr  <= 1'b0;
      end else if (start_nxt) begin
         rg   <= rg_n;
         duty <= duty_n;
         pol  <= pol_in;
         arr  <= bal_in & ~arr;
      end
   end
endmodule

// File: rtl/sevlvl_deadband.sv
module sevlvl_deadband #(
   parameter int DT_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic [DT_W-1:0] dead,
   input  logic            raw,
   output logic            on,
   output logic            on_n
);
   logic            raw_q;
   logic            act_q;
   logic [DT_W-1:0] hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw_q <= 1'b0;
         act_q <= 1'b0;
         hold  <= '0;
      end else begin
         act_q <= run;
         if (!run) begin
            raw_q <= 1'b0;
            hold  <= '0;
         end else begin
            raw_q <= raw;
            if (raw != raw_q)   hold <= dead;
            else if (hold != '0) hold <= hold - DT_W'(1);
         end
      end
   end

   assign on   = act_q &  raw_q & (hold == '0);
   assign on_n = act_q & ~raw_q & (hold == '0);
endmodule

// File: rtl/sevlvl_mod.sv
module sevlvl_mod
   import sevlvl_pkg::*;
#(
   parameter int CNT_W     = 10,
   parameter int CTRL_W    = 10,
   parameter int TOP       = 42,
   parameter int DT_W      = 4,
   parameter bit MIRROR_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mod_en,
   input  logic [CTRL_W-1:0] ctrl_word,
   input  logic              pol_pos,
   input  logic              bal_en,
   input  logic [DT_W-1:0]   dead_clks,
   output logic              g_rp,
   output logic              g_rp_n,
   output logic              g_rn,
   output logic              g_rn_n,
   output logic              g_mid,
   output logic              g_mid_n,
   output logic              g_top,
   output logic              g_top_n,
   output logic              g_arr
);
   localparam logic [CNT_W-1:0] TOPV = CNT_W'(TOP);

   if (TOP < 2 || TOP >= (2 ** CNT_W)) begin : g_bad_top
      $error("TOP must be at least 2 and fit in CNT_W bits");
   end
   if (3 * TOP >= (2 ** CTRL_W)) begin : g_bad_ctrl
      $error("CTRL_W too narrow for a full scale of 3*TOP");
   end
   if (DT_W < 1) begin : g_bad_dt
      $error("DT_W must be at least 1");
   end

   logic [CNT_W-1:0] cnt;
   logic             start_nxt;
   region_e          rg;
   logic [CNT_W-1:0] duty;
   logic             pol_q;
   logic             arr_q;
   logic [CNT_W-1:0] car_sel;
   logic             pwm;
   logic [NPAIR-1:0] raw;
   logic [NPAIR-1:0] mains;
   logic [NPAIR-1:0] comps;

   sevlvl_carrier #(.CNT_W(CNT_W), .TOP(TOP)) u_car (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (mod_en),
      .cnt       (cnt),
      .start_nxt (start_nxt)
   );

   sevlvl_sample #(.CNT_W(CNT_W), .CTRL_W(CTRL_W), .TOP(TOP)) u_smp (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (mod_en),
      .start_nxt (start_nxt),
      .ctrl      (ctrl_word),
      .pol_in    (pol_pos),
      .bal_in    (bal_en),
      .rg        (rg),
      .duty      (duty),
      .pol       (pol_q),
      .arr       (arr_q)
   );

   // mid and top carriers: mirrored on alternate-arrangement periods
   if (MIRROR_EN) begin : g_mirror
      assign car_sel = (rg != RG_LOW && arr_q) ? (TOPV - cnt) : cnt;
   end else begin : g_plain
      assign car_sel = cnt;
   end

   assign pwm = car_sel < duty;

   always_comb begin
      raw = '0;
      case (rg)
         RG_LOW: begin
            raw[IDX_RP] = pol_q & pwm;
            raw[IDX_RN] = ~pol_q & pwm;
         end
         RG_MID: begin
            raw[IDX_RP]  = pol_q;
            raw[IDX_RN]  = ~pol_q;
            raw[IDX_MID] = pwm;
         end
         default: begin
            raw[IDX_RP]  = pol_q;
            raw[IDX_RN]  = ~pol_q;
            raw[IDX_MID] = 1'b1;
            raw[IDX_TOP] = pwm;
         end
      endcase
   end

   for (genvar i = 0; i < NPAIR; i++) begin : g_pair
      sevlvl_deadband #(.DT_W(DT_W)) u_db (
         .clk   (clk),
         .rst_n (rst_n),
         .run   (mod_en),
         .dead  (dead_clks),
         .raw   (raw[i]),
         .on    (mains[i]),
         .on_n  (comps[i])
      );
   end

   assign g_rp    = mains[IDX_RP];
   assign g_rp_n  = comps[IDX_RP];
   assign g_rn    = mains[IDX_RN];
   assign g_rn_n  = comps[IDX_RN];
   assign g_mid   = mains[IDX_MID];
   assign g_mid_n = comps[IDX_MID];
   assign g_top   = mains[IDX_TOP];
   assign g_top_n = comps[IDX_TOP];
   assign g_arr   = arr_q;
endmodule

// File: rtl/sevlvl_chk.sv
module sevlvl_chk #(
   parameter int DT_W = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            mod_en,
   input logic [DT_W-1:0] dead_clks,
   input logic            g_rp,
   input logic            g_rp_n,
   input logic            g_rn,
   input logic            g_rn_n,
   input logic            g_mid,
   input logic            g_mid_n,
   input logic            g_top,
   input logic            g_top_n,
   input logic            g_arr
);
   logic [8:0] all_g;
   assign all_g = {g_rp, g_rp_n, g_rn, g_rn_n, g_mid, g_mid_n, g_top, g_top_n, g_arr};

   // R1
   gates_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mod_en |=> (all_g == 9'd0));

   // R7
   pair_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(g_rp && g_rp_n) && !(g_rn && g_rn_n) && !(g_mid && g_mid_n) && !(g_top && g_top_n));

   // R7
   dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dead_clks != '0 && $stable(dead_clks) && $rose(g_mid)) |-> $past(!g_mid_n));

   // R8
   top_needs_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      g_top |-> g_mid);

   // R4
   one_leg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(g_rp && g_rn));
endmodule

bind sevlvl_mod sevlvl_chk #(.DT_W(DT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mod_en    (mod_en),
   .dead_clks (dead_clks),
   .g_rp      (g_rp),
   .g_rp_n    (g_rp_n),
   .g_rn      (g_rn),
   .g_rn_n    (g_rn_n),
   .g_mid     (g_mid),
   .g_mid_n   (g_mid_n),
   .g_top     (g_top),
   .g_top_n   (g_top_n),
   .g_arr     (g_arr)
);

// File: tb/tb_sevlvl_mod.sv
`timescale 1ns/1ps
module tb_sevlvl_mod;
   localparam int T      = 42;
   localparam int CNT_W  = 10;
   localparam int CTRL_W = 10;
   localparam int DT_W   = 4;
   localparam int P      = 2 * T;
   localparam int WIN    = 4 * P;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              mod_en = 1'b0;
   logic [CTRL_W-1:0] ctrl_word = '0;
   logic              pol_pos = 1'b1;
   logic              bal_en = 1'b0;
   logic [DT_W-1:0]   dead_clks = '0;
   logic g_rp, g_rp_n, g_rn, g_rn_n, g_mid, g_mid_n, g_top, g_top_n, g_arr;

   always #10 clk = ~clk;

   sevlvl_mod #(.CNT_W(CNT_W), .CTRL_W(CTRL_W), .TOP(T), .DT_W(DT_W)) dut (
      .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .ctrl_word(ctrl_word),
      .pol_pos(pol_pos), .bal_en(bal_en), .dead_clks(dead_clks),
      .g_rp(g_rp), .g_rp_n(g_rp_n), .g_rn(g_rn), .g_rn_n(g_rn_n),
      .g_mid(g_mid), .g_mid_n(g_mid_n), .g_top(g_top), .g_top_n(g_top_n),
      .g_arr(g_arr)
   );

   int n_chk = 0;
   int n_err = 0;

   // scoreboard queues
   string tag_q[$];
   int    win_q[$];
   bit    mo_q[$];
   int    exp_q[$];
   int    pending = 0;

   string names[9] = '{"g_rp", "g_rp_n", "g_rn", "g_rn_n", "g_mid",
                       "g_mid_n", "g_top", "g_top_n", "g_arr"};

   function automatic void chk(string tag, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endfunction

   // per-period on-count of a main output: mode 0 off, 1 held, 2 modulated
   function automatic int per_main(int mode, int h, int dt);
      if (mode == 0) return 0;
      if (mode == 1) return P;
      return (h == 0) ? 0 : h - dt;
   endfunction

   function automatic int per_comp(int mode, int h, int dt);
      if (mode == 0) return P;
      if (mode == 1) return 0;
      return (h == 0) ? P : P - h - dt;
   endfunction

   function automatic void fill_exp(int c, bit pol, bit bal, int dt, output int e[9]);
      int k, r, d, h;
      int m[4];
      k = (c > 3 * T) ? 3 * T : c;
      r = (k < T) ? 0 : ((k < 2 * T) ? 1 : 2);
      d = k - r * T;
      h = (d == 0) ? 0 : 2 * d - 1;
      m[0] = pol  ? ((r == 0) ? 2 : 1) : 0;
      m[1] = !pol ? ((r == 0) ? 2 : 1) : 0;
      m[2] = (r == 0) ? 0 : ((r == 1) ? 2 : 1);
      m[3] = (r == 2) ? 2 : 0;
      for (int i = 0; i < 4; i++) begin
         e[2*i]   = 4 * per_main(m[i], h, dt);
         e[2*i+1] = 4 * per_comp(m[i], h, dt);
      end
      e[8] = bal ? WIN / 2 : 0;
   endfunction

   task automatic push_item(string tag, int win, bit mid_only, int e[9]);
      tag_q.push_back(tag);
      win_q.push_back(win);
      mo_q.push_back(mid_only);
      for (int j = 0; j < 9; j++) exp_q.push_back(e[j]);
      pending++;
   endtask

   // monitor: counts high cycles over the window, compares with the queue
   initial begin
      forever begin
         string tg;
         int    w;
         bit    mo;
         int    ex[9];
         int    cn[9];
         wait (pending != 0);
         tg = tag_q.pop_front();
         w  = win_q.pop_front();
         mo = mo_q.pop_front();
         for (int j = 0; j < 9; j++) begin
            ex[j] = exp_q.pop_front();
            cn[j] = 0;
         end
         for (int i = 0; i < w; i++) begin
            @(negedge clk);
            cn[0] += int'(g_rp);   cn[1] += int'(g_rp_n);
            cn[2] += int'(g_rn);   cn[3] += int'(g_rn_n);
            cn[4] += int'(g_mid);  cn[5] += int'(g_mid_n);
            cn[6] += int'(g_top);  cn[7] += int'(g_top_n);
            cn[8] += int'(g_arr);
         end
         for (int j = 0; j < 9; j++)
            if (!mo || j == 4 || j == 5) chk(tg, names[j], cn[j], ex[j]);
         pending--;
      end
   end

   task automatic setup(int c, bit pol, bit bal, int dt);
      @(negedge clk);
      mod_en    = 1'b0;
      ctrl_word = CTRL_W'(c);
      pol_pos   = pol;
      bal_en    = bal;
      dead_clks = DT_W'(dt);
      repeat (3) @(negedge clk);
      mod_en = 1'b1;
      repeat (3 * P) @(negedge clk);
   endtask

   task automatic run_case(string tag, int c, bit pol, bit bal, int dt);
      int e[9];
      setup(c, pol, bal, dt);
      fill_exp(c, pol, bal, dt, e);
      push_item(tag, WIN, 1'b0, e);
      wait (pending == 0);
   endtask

   function automatic int all_gates();
      return int'({g_rp, g_rp_n, g_rn, g_rn_n, g_mid, g_mid_n, g_top, g_top_n, g_arr});
   endfunction

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      int e[9];
      logic prev;
      repeat (3) @(negedge clk);
      chk("R1 under reset", "all gates", all_gates(), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 idle after reset", "all gates", all_gates(), 0);

      run_case("R4 low region positive", 20, 1'b1, 1'b0, 0);
      run_case("R4 low region negative", 30, 1'b0, 1'b0, 0);
      run_case("R5 mid region positive", 60, 1'b1, 1'b0, 0);
      run_case("R5 R10 mid region negative balanced", 52, 1'b0, 1'b1, 0);
      run_case("R6 R8 R10 top region balanced", 114, 1'b1, 1'b1, 0);
      run_case("R2 word at one third", 42, 1'b1, 1'b0, 0);
      run_case("R2 word at two thirds", 84, 1'b0, 1'b0, 0);
      run_case("R3 zero word", 0, 1'b1, 1'b0, 0);
      run_case("R3 full scale", 126, 1'b1, 1'b0, 0);
      run_case("R2 clamp above full scale", 1023, 1'b0, 1'b1, 0);
      run_case("R7 dead gap mid", 52, 1'b1, 1'b0, 3);
      run_case("R7 dead gap low negative", 20, 1'b0, 1'b0, 5);

      // R9: mid-period word change must not touch the running period
      setup(52, 1'b1, 1'b1, 0);
      prev = g_arr;
      do @(negedge clk); while (g_arr == prev);
      fill_exp(52, 1'b1, 1'b1, 0, e);
      e[4] = 2 * 10 - 1;
      e[5] = P - (2 * 10 - 1);
      push_item("R9 capture at valley only", P, 1'b1, e);
      repeat (T) @(negedge clk);
      ctrl_word = CTRL_W'(72);
      wait (pending == 0);

      // R1: disable forces all gates off at the next edge
      setup(114, 1'b1, 1'b1, 2);
      @(negedge clk);
      mod_en = 1'b0;
      @(negedge clk);
      chk("R1 disable", "all gates", all_gates(), 0);

      summary();
      $finish;
   end
endmodule